// File: doc/BRIEF.md
# Byte Serializer with Preamble Default and Rate Divider

This block turns a stream of payload bytes into a serial modulation bit at a programmable bit rate derived from a 10 MHz reference clock. It holds two byte stages in series. The upper stage shifts out one bit at a time, most significant bit first. The lower stage holds the next byte to send. Both stages start out holding the alternating pattern 0xAA, so a preamble goes out as soon as transmission is enabled, even if no payload has been written.

The caller paces its writes with a byte-request flag. The flag rises when the upper stage has finished a byte and the lower stage has moved up, leaving the lower slot free. A write strobe fills that slot and lowers the flag. If a slot is still free when the next byte boundary arrives, the block sends an idle 0xAA byte in its place.

A polarity input selects the meaning of the output level. When polarity is clear, a payload 1 drives the modulation bit high, which selects the upper frequency. When polarity is set, the level is inverted. Dropping the enable discards whatever has not yet been sent.

Top module: `tx_byte_serializer`

## Requirements
- R1: While reset is held and just after it is released: byte_req is 0, overrun is 0, bit_stb is 0, and both stages hold 0xAA, so ser_bit equals 1 XOR invert.
- R2: With tx_en high and nothing written, the output repeats the byte 0xAA indefinitely (1,0,1,0,...), beginning with a 1.
- R3: While tx_en is high and rate_sel is held constant, bit_stb is high for exactly one cycle in every 29×(rate_sel+1) cycles. The first pulse falls in the 29×(rate_sel+1)-th cycle with tx_en high, and each shift takes effect at the clock edge that ends a pulse.
- R4: Bits leave the upper stage most significant bit first. ser_bit equals the current bit XOR invert, and it changes only after a bit_stb pulse.
- R5: byte_req rises at the edge that completes the eighth bit of a byte. An accepted write lowers it at the next edge, unless that same edge is also a byte boundary.
- R6: A write with load_stb high while byte_req is high is accepted. The byte is sent whole, right after the byte in progress. If the write's cycle is also the final bit cycle of a byte, the written byte moves straight into the upper stage, and byte_req stays high.
- R7: A write with load_stb high while byte_req is low (including while tx_en is low) is ignored: the byte is never sent. It also sets overrun, which stays high until reset.
- R8: When tx_en is low at an edge, both stages return to 0xAA and byte_req and the divider are cleared. Unsent bits, including a written but unsent byte, are lost.
- R9: At a byte boundary with no write in the lower slot, an idle 0xAA byte follows, and byte_req stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low discards and restarts |
| load_stb | input | 1 | One-cycle write strobe for load_byte |
| load_byte | input | 8 | Payload byte to queue |
| rate_sel | input | 8 | Rate divisor N; bit period is 29×(N+1) clocks |
| invert | input | 1 | Output polarity; set inverts the modulation level |
| ser_bit | output | 1 | Serial modulation bit |
| byte_req | output | 1 | High while the lower byte slot is free |
| bit_stb | output | 1 | One-cycle pulse in the last cycle of each bit |
| overrun | output | 1 | Sticky flag: a write arrived with no free slot |

## Verification
The case that needs the most care is a write strobe that lands in the final bit cycle of a byte, the same cycle in which the lower stage moves up. The bench tracks the bit position in its own model and raises load_stb exactly on that cycle. It does this twice: once with the slot free, where the byte must go straight into the upper stage with byte_req left high, and once with the slot full, where the byte must be dropped and overrun set. In both cases the bytes rebuilt from ser_bit at each bit_stb are compared against the expected order, and every output is compared with the model on every clock.

// File: rtl/txser_pkg.sv
package txser_pkg;
  localparam logic [7:0] PREAMBLE_BYTE = 8'hAA;

  // Reference clocks per transmitted bit.
  function automatic int unsigned bit_period(input int unsigned prescale,
                                             input int unsigned rate);
    return prescale * (rate + 1);
  endfunction
endpackage

// File: rtl/txser_rate_div.sv
module txser_rate_div #(
  parameter int PRESCALE = 29,
  parameter int RATE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int PW = $clog2(PRESCALE);

  logic [PW-1:0]     pre_q;
  logic [RATE_W-1:0] rc_q;
  logic              pre_last;
  logic              rate_last;

  assign pre_last  = (pre_q == PW'(PRESCALE - 1));
  assign rate_last = (rc_q >= rate);
  assign tick      = run && pre_last && rate_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
      rc_q  <= '0;
    end else if (pre_last) begin
      pre_q <= '0;
      rc_q  <= rate_last ? '0 : rc_q + RATE_W'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/txser_shifter.sv
module txser_shifter #(
  parameter int          BYTE_W = 8,
  parameter logic [BYTE_W-1:0] IDLE = txser_pkg::PREAMBLE_BYTE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              top_bit,
  output logic              req,
  output logic              ovr,
  output logic              byte_done
);
  localparam int CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CW-1:0]     bit_q;
  logic              req_q;
  logic              ovr_q;
  logic              accept;
  logic              reject;

  assign accept    = run && load && req_q;
  assign reject    = load && !accept;
  assign byte_done = tick && (bit_q == CW'(BYTE_W - 1));
  assign top_bit   = hi_q[BYTE_W-1];
  assign req       = req_q;
  assign ovr       = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= IDLE;
      lo_q  <= IDLE;
      bit_q <= '0;
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (reject) ovr_q <= 1'b1;
      if (!run) begin
        hi_q  <= IDLE;
        lo_q  <= IDLE;
        bit_q <= '0;
        req_q <= 1'b0;
      end else if (byte_done) begin
        hi_q  <= accept ? din : lo_q;
        lo_q  <= IDLE;
        bit_q <= '0;
        req_q <= 1'b1;
      end else begin
        if (tick) begin
          hi_q  <= {hi_q[BYTE_W-2:0], 1'b0};
          bit_q <= bit_q + CW'(1);
        end
        if (accept) begin
          lo_q  <= din;
          req_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tx_byte_serializer.sv
module tx_byte_serializer #(
  parameter int PRESCALE = 29,
  parameter int RATE_W   = 8,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              load_stb,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              invert,
  output logic              ser_bit,
  output logic              byte_req,
  output logic              bit_stb,
  output logic              overrun
);
  logic byte_done;
  logic top_bit;

  txser_rate_div #(.PRESCALE(PRESCALE), .RATE_W(RATE_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tx_en),
    .rate (rate_sel),
    .tick (bit_stb)
  );

  txser_shifter #(.BYTE_W(BYTE_W)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tx_en),
    .tick     (bit_stb),
    .load     (load_stb),
    .din      (load_byte),
    .top_bit  (top_bit),
    .req      (byte_req),
    .ovr      (overrun),
    .byte_done(byte_done)
  );

  assign ser_bit = top_bit ^ invert;
endmodule

// File: rtl/txser_chk.sv
module txser_chk #(
  parameter int PRESCALE = 29,
  parameter int RATE_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              load_stb,
  input logic [RATE_W-1:0] rate_sel,
  input logic              byte_req,
  input logic              overrun,
  input logic              bit_stb,
  input logic              byte_done,
  input logic              top_bit
);
  logic [31:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en || bit_stb) gap_q <= '0;
    else                             gap_q <= gap_q + 32'd1;
  end

  a_r3_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (gap_q == txser_pkg::bit_period(PRESCALE, 32'(rate_sel)) - 32'd1));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  a_r4_hold_between_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !bit_stb) |=> $stable(top_bit));

  a_r5_req_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && byte_done) |=> byte_req);

  a_r5_load_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && load_stb && byte_req && !byte_done) |=> !byte_req);

  a_r7_reject_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !byte_req) |=> overrun);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r8_disable_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!byte_req && top_bit));
endmodule

bind tx_byte_serializer txser_chk #(.PRESCALE(PRESCALE), .RATE_W(RATE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .load_stb (load_stb),
  .rate_sel (rate_sel),
  .byte_req (byte_req),
  .overrun  (overrun),
  .bit_stb  (bit_stb),
  .byte_done(byte_done),
  .top_bit  (top_bit)
);

// File: tb/sim_tx_byte_serializer.sv
module sim_tx_byte_serializer;
  logic       clk = 1'b0;
  logic       rst_n, tx_en, load_stb, invert;
  logic [7:0] load_byte, rate_sel;
  logic       ser_bit, byte_req, bit_stb, overrun;

  always #2 clk = ~clk;

  tx_byte_serializer u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .load_stb(load_stb),
    .load_byte(load_byte), .rate_sel(rate_sel), .invert(invert),
    .ser_bit(ser_bit), .byte_req(byte_req), .bit_stb(bit_stb), .overrun(overrun)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Behavioural reference state
  int m_tick, m_bit, m_cur, m_nxt;
  bit m_req, m_ovr;
  int per;
  bit stb, acc;

  // Rebuilt byte stream
  logic [7:0] cap;
  int         capn;
  logic [7:0] got[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_bit = 0; m_cur = 8'hAA; m_nxt = 8'hAA; m_req = 0; m_ovr = 0;
    end else begin
      per = 29 * (int'(rate_sel) + 1);
      stb = tx_en && (m_tick == per - 1);
      acc = load_stb && m_req && tx_en;
      if (load_stb && !acc) m_ovr = 1;
      if (!tx_en) begin
        m_tick = 0; m_bit = 0; m_cur = 8'hAA; m_nxt = 8'hAA; m_req = 0;
      end else if (stb) begin
        m_tick = 0;
        if (m_bit == 7) begin
          m_cur = acc ? int'(load_byte) : m_nxt;
          m_nxt = 8'hAA; m_req = 1; m_bit = 0;
        end else begin
          m_bit++;
          if (acc) begin m_nxt = int'(load_byte); m_req = 0; end
        end
      end else begin
        m_tick++;
        if (acc) begin m_nxt = int'(load_byte); m_req = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 bit_stb", int'(bit_stb),
          int'(tx_en && (m_tick == 29 * (int'(rate_sel) + 1) - 1)));
      chk("R4 ser_bit", int'(ser_bit), ((m_cur >> (7 - m_bit)) & 1) ^ int'(invert));
      chk("R5 byte_req", int'(byte_req), int'(m_req));
      chk("R7 overrun", int'(overrun), int'(m_ovr));
      if (tx_en && bit_stb) begin
        cap = {cap[6:0], ser_bit ^ invert};
        capn++;
        if (capn == 8) begin got.push_back(cap); capn = 0; end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected<%0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic [7:0] rate, input logic inv);
    rst_n = 0; tx_en = 0; load_stb = 0; load_byte = 0; rate_sel = rate; invert = inv;
    repeat (3) step();
    rst_n = 1;
    got.delete(); capn = 0;
    step();
  endtask

  task automatic send(input logic [7:0] b);
    while (!byte_req) step();
    load_stb = 1; load_byte = b;
    step();
    load_stb = 0;
  endtask

  task automatic wait_bytes(input int n);
    while (got.size() < n) step();
  endtask

  task automatic wait_boundary();
    while (!(bit_stb && m_bit == 7)) step();
  endtask

  initial begin
    int n;
    logic [7:0] exp_b[7];
    do_reset(8'd0, 1'b0);
    chk("R1 byte_req", int'(byte_req), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 bit_stb", int'(bit_stb), 0);
    chk("R1 ser_bit", int'(ser_bit), 1);

    // R2: preamble with no writes
    tx_en = 1;
    wait_bytes(4);
    for (int i = 0; i < 4; i++) chk("R2 idle byte", int'(got[i]), 8'hAA);

    // R6/R9: paced writes at rate 1
    do_reset(8'd1, 1'b0);
    tx_en = 1;
    send(8'h3C); send(8'hF0); send(8'h81); send(8'h00);
    wait_bytes(7);
    exp_b = '{8'hAA, 8'hAA, 8'h3C, 8'hF0, 8'h81, 8'h00, 8'hAA};
    for (int i = 0; i < 6; i++) chk("R6 byte order", int'(got[i]), int'(exp_b[i]));
    chk("R9 idle filler", int'(got[6]), int'(exp_b[6]));

    // R6/R7: write coincident with a byte boundary
    do_reset(8'd0, 1'b0);
    tx_en = 1;
    while (!byte_req) step();
    wait_boundary();
    load_stb = 1; load_byte = 8'h5A;
    step();
    load_stb = 0;
    chk("R6 req stays high", int'(byte_req), 1);
    send(8'hC3);
    wait_boundary();
    load_stb = 1; load_byte = 8'h99;
    step();
    load_stb = 0;
    chk("R7 overrun set", int'(overrun), 1);
    wait_bytes(5);
    chk("R6 direct byte", int'(got[2]), 8'h5A);
    chk("R7 queued byte", int'(got[3]), 8'hC3);
    chk("R7 rejected byte absent", int'(got[4]), 8'hAA);
    chk("R7 overrun sticky", int'(overrun), 1);

    // R4: inverted polarity at rate 2
    do_reset(8'd2, 1'b1);
    chk("R4 inverted idle level", int'(ser_bit), 0);
    tx_en = 1;
    send(8'h0F);
    wait_bytes(3);
    chk("R4 inverted data", int'(got[2]), 8'h0F);

    // R8: disable discards a queued byte
    do_reset(8'd0, 1'b0);
    tx_en = 1;
    send(8'hE7);
    repeat (5) step();
    tx_en = 0;
    step();
    chk("R8 byte_req cleared", int'(byte_req), 0);
    chk("R8 ser_bit preamble", int'(ser_bit), 1);
    chk("R8 bit_stb idle", int'(bit_stb), 0);
    got.delete(); capn = 0;
    tx_en = 1;
    wait_bytes(3);
    chk("R8 queued byte lost", int'(got[2]), 8'hAA);

    // R3: spacing at rate 3
    do_reset(8'd3, 1'b0);
    tx_en = 1;
    n = 0;
    while (!bit_stb) begin step(); n++; end
    chk("R3 first pulse", n, 115);
    step();
    n = 1;
    while (!bit_stb) begin step(); n++; end
    chk("R3 pulse spacing", n, 116);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule